// File: doc/BRIEF.md
# Pattern Column Translator

This block sits on the command/address side of a memory rank made of several chips that share one command and address bus. Each chip has a small identity register. A column command carries a column address and a short pattern code, and every chip turns these into its own column. For a read or a write, a chip forms its column as the broadcast column XOR (its identity AND the pattern), applied to the low pattern-width bits. Any other command leaves the address unchanged on every chip. The controller lays each line across the chips with a butterfly shuffle keyed on the column's low bits. With that layout, one command gathers or scatters a power-of-two strided set of words, and no two of the words fall in the same chip.

Commands enter through a valid/ready handshake. The translated per-chip columns leave one cycle later through a second valid/ready handshake, held in a single output register. `cmd_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output holds its value and no new command is taken. Chip identities come up from reset as each chip's own index, widened to the pattern width. They can be rewritten through a plain write port.

Top module: `pattern_col_translator`

## Requirements
- R1: Command codes are NOP=0, ACTIVATE=1, PRECHARGE=2, READ=3, WRITE=4 and REFRESH=5; codes 6 and 7 are also accepted. For every code other than 3 and 4, each chip's output column equals the input column.
- R2: For READ (3) and WRITE (4), chip k's output column equals the input column with bits [PAT_W-1:0] XORed by (id_k AND pattern). Column bits at PAT_W and above pass through unchanged.
- R3: Pattern 0 gives the same input column on every chip, for all commands.
- R4: With 4 chips and reset identities, READ of column 0 with pattern 3 gives columns 0,1,2,3 on chips 0..3. READ of column 2 with pattern 0 gives 2,2,2,2.
- R5: After reset, chip k's identity is k widened to PAT_W bits by repeating its log2(NUM_CHIPS)-bit value: bit b of the identity is bit (b mod log2(NUM_CHIPS)) of k. With 4 chips and PAT_W=3, pattern 4 flips column bit 2 on chips 1 and 3 only.
- R6: When `cfg_we` is high at a clock edge, chip `cfg_sel` loads `cfg_id`, widened as in R5. A command accepted at that same edge still uses the old identity. Commands accepted at later edges use the new one.
- R7: A command accepted at a clock edge appears on `out_valid`/`out_cmd`/`out_col` right after that edge.
- R8: `cmd_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_cmd` and `out_col` hold their values.
- R9: When a line at column C is stored with word j in chip j XOR (C mod 4), the word chip k returns is at row index col_k*4 + (k XOR (col_k mod 4)). Under that layout, patterns 0, 1 and 3 return four distinct words at strides 1, 2 and 4. Pattern 2 at column 0 returns words at steps (1,7,1).
- R10: While reset is asserted, `out_valid` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Identity write strobe |
| cfg_sel | input | log2(NUM_CHIPS) | Chip whose identity is written |
| cfg_id | input | log2(NUM_CHIPS) | Physical identity value to store |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_code | input | 3 | Command code (R1 encoding) |
| cmd_col | input | COL_W | Broadcast column address |
| cmd_pat | input | PAT_W | Pattern code |
| out_valid | output | 1 | Translated columns present |
| out_ready | input | 1 | Consumer takes translated columns |
| out_cmd | output | 3 | Command code of the held result |
| out_col | output | NUM_CHIPS*COL_W | Chip k's column in bits [k*COL_W +: COL_W] |

## Verification
The properties assume that the consumer only drops `out_ready`, and never relies on the output changing, while a result is held. They also assume that the upper column bits and the pattern are stable across the cycle the command is taken. The bench drives all inputs on the falling edge, so every handshake sees settled values. It keeps `cfg_id` within the chip count and restores the reset identities before the directed gather cases. Back-pressure is applied only through `out_ready`, so a stalled result is never overwritten.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_REF = 3'd5
  } pct_cmd_e;

  function automatic logic is_column_cmd(input logic [CMD_W-1:0] code);
    return (code == CMD_RD) || (code == CMD_WR);
  endfunction
endpackage

// File: rtl/pct_id_bank.sv
module pct_id_bank #(
  parameter int NUM_CHIPS = 4,
  parameter int PAT_W     = 3,
  parameter bit REPLICATE = 1'b1,
  localparam int ID_W     = $clog2(NUM_CHIPS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [ID_W-1:0]              cfg_sel,
  input  logic [ID_W-1:0]              cfg_id,
  output logic [NUM_CHIPS*PAT_W-1:0]   ids_flat
);
  // Spread a physical identity over the pattern width. In replicate mode the
  // physical bits repeat; otherwise bits above the physical width stay zero.
  function automatic logic [PAT_W-1:0] widen_id(input logic [ID_W-1:0] phys);
    logic [PAT_W-1:0] r;
    for (int b = 0; b < PAT_W; b++) begin
      r[b] = (REPLICATE || (b < ID_W)) ? phys[b % ID_W] : 1'b0;
    end
    return r;
  endfunction

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
    logic [PAT_W-1:0] id_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q <= widen_id(ID_W'(g));
      end else if (cfg_we && (cfg_sel == ID_W'(g))) begin
        id_q <= widen_id(cfg_id);
      end
    end
    assign ids_flat[g*PAT_W +: PAT_W] = id_q;
  end
endmodule

// File: rtl/pct_lane.sv
module pct_lane #(
  parameter int COL_W = 8,
  parameter int PAT_W = 3
) (
  input  logic             col_cmd,
  input  logic [COL_W-1:0] col_in,
  input  logic [PAT_W-1:0] pat,
  input  logic [PAT_W-1:0] chip_id,
  output logic [COL_W-1:0] col_out
);
  logic [PAT_W-1:0] flip;
  assign flip    = col_cmd ? (chip_id & pat) : '0;
  assign col_out = col_in ^ COL_W'(flip);
endmodule

// File: rtl/pattern_col_translator.sv
module pattern_col_translator
  import pct_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int COL_W     = 8,
  parameter int PAT_W     = 3,
  parameter bit REPLICATE = 1'b1,
  localparam int ID_W     = $clog2(NUM_CHIPS),
  localparam int OUT_W    = NUM_CHIPS * COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_sel,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [PAT_W-1:0]  cmd_pat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CMD_W-1:0]  out_cmd,
  output logic [OUT_W-1:0]  out_col
);
  logic [NUM_CHIPS*PAT_W-1:0] ids_flat;
  logic [OUT_W-1:0]           xcol_d;
  logic                       col_cmd;
  logic                       accept;

  assign cmd_ready = !out_valid || out_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign col_cmd   = is_column_cmd(cmd_code);

  pct_id_bank #(
    .NUM_CHIPS (NUM_CHIPS),
    .PAT_W     (PAT_W),
    .REPLICATE (REPLICATE)
  ) u_ids (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_id   (cfg_id),
    .ids_flat (ids_flat)
  );

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_lane
    pct_lane #(
      .COL_W (COL_W),
      .PAT_W (PAT_W)
    ) u_lane (
      .col_cmd (col_cmd),
      .col_in  (cmd_col),
      .pat     (cmd_pat),
      .chip_id (ids_flat[k*PAT_W +: PAT_W]),
      .col_out (xcol_d[k*COL_W +: COL_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cmd   <= '0;
      out_col   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_cmd   <= cmd_code;
      out_col   <= xcol_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pattern_col_translator_chk.sv
module pattern_col_translator_chk
  import pct_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int COL_W     = 8,
  parameter int PAT_W     = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [CMD_W-1:0]           cmd_code,
  input logic [COL_W-1:0]           cmd_col,
  input logic [PAT_W-1:0]           cmd_pat,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [CMD_W-1:0]           out_cmd,
  input logic [NUM_CHIPS*COL_W-1:0] out_col
);
  logic [COL_W-1:0] last_col;
  logic [PAT_W-1:0] last_pat;
  logic             lanes_match;
  logic             upper_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_col <= '0;
      last_pat <= '0;
    end else if (cmd_valid && cmd_ready) begin
      last_col <= cmd_col;
      last_pat <= cmd_pat;
    end
  end

  always_comb begin
    lanes_match = 1'b1;
    upper_match = 1'b1;
    for (int k = 0; k < NUM_CHIPS; k++) begin
      if (out_col[k*COL_W +: COL_W] != last_col) lanes_match = 1'b0;
      if ((out_col[k*COL_W +: COL_W] >> PAT_W) != (last_col >> PAT_W)) upper_match = 1'b0;
    end
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_column_cmd(out_cmd)) |-> lanes_match);

  assert_upper_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> upper_match);

  assert_default_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (last_pat == '0)) |-> lanes_match);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_cmd)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !cmd_ready);
endmodule

bind pattern_col_translator pattern_col_translator_chk #(
  .NUM_CHIPS (NUM_CHIPS),
  .COL_W     (COL_W),
  .PAT_W     (PAT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_col   (cmd_col),
  .cmd_pat   (cmd_pat),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_cmd   (out_cmd),
  .out_col   (out_col)
);

// File: tb/pattern_col_translator_bench.sv
`timescale 1ns/1ps
module pattern_col_translator_bench;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int P  = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [IW-1:0] cfg_id = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_code = '0;
  logic [CW-1:0] cmd_col = '0;
  logic [P-1:0]  cmd_pat = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [2:0]    out_cmd;
  logic [N*CW-1:0] out_col;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int            mid [N];
  bit            m_valid = 1'b0;
  logic [2:0]    m_cmd;
  logic [CW-1:0] m_col [N];

  always #10 clk = ~clk;

  pattern_col_translator #(.NUM_CHIPS(N), .COL_W(CW), .PAT_W(P)) u_pattern_col_translator (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_id(cfg_id),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_col(cmd_col), .cmd_pat(cmd_pat), .out_valid(out_valid),
    .out_ready(out_ready), .out_cmd(out_cmd), .out_col(out_col)
  );

  function automatic logic [CW-1:0] lane(input int k);
    return out_col[k*CW +: CW];
  endfunction

  function automatic logic [P-1:0] widen(input int phys);
    logic [P-1:0] r;
    for (int b = 0; b < P; b++) r[b] = ((phys >> (b % IW)) & 1) != 0;
    return r;
  endfunction

  function automatic logic [CW-1:0] model_col(input int chip, input logic [2:0] c,
                                               input logic [CW-1:0] col, input logic [P-1:0] pat);
    logic [CW-1:0] r;
    logic [P-1:0]  w;
    r = col;
    if (c == 3'd3 || c == 3'd4) begin
      w = widen(mid[chip]);
      for (int b = 0; b < P; b++) r[b] = col[b] ^ (w[b] & pat[b]);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: drive after a falling edge, predict the rising edge, compare at the next falling edge.
  task automatic drive(input bit v, input logic [2:0] c, input logic [CW-1:0] col,
                       input logic [P-1:0] pat, input bit ordy, input bit we,
                       input logic [IW-1:0] sel, input logic [IW-1:0] id, input string tag);
    bit exp_rdy;
    cmd_valid = v; cmd_code = c; cmd_col = col; cmd_pat = pat;
    out_ready = ordy; cfg_we = we; cfg_sel = sel; cfg_id = id;
    #1;
    exp_rdy = !m_valid || ordy;
    chk(cmd_ready == exp_rdy, "R8", "cmd_ready", cmd_ready, exp_rdy);
    if (m_valid && ordy) m_valid = 1'b0;
    if (v && exp_rdy) begin
      m_valid = 1'b1;
      m_cmd = c;
      for (int k = 0; k < N; k++) m_col[k] = model_col(k, c, col, pat);
    end
    if (we) mid[sel] = int'(id);
    @(negedge clk);
    chk(out_valid == m_valid, "R7", {tag, " out_valid"}, out_valid, m_valid);
    if (m_valid) begin
      chk(out_cmd == m_cmd, tag, "out_cmd", out_cmd, m_cmd);
      for (int k = 0; k < N; k++)
        chk(lane(k) == m_col[k], tag, $sformatf("lane%0d", k), lane(k), m_col[k]);
    end
  endtask

  task automatic cmd(input logic [2:0] c, input logic [CW-1:0] col,
                     input logic [P-1:0] pat, input string tag);
    drive(1'b1, c, col, pat, 1'b1, 1'b0, '0, '0, tag);
  endtask

  task automatic expect_lanes(input int a0, input int a1, input int a2, input int a3,
                              input string req);
    int e [N];
    e[0] = a0; e[1] = a1; e[2] = a2; e[3] = a3;
    for (int k = 0; k < N; k++)
      chk(int'(lane(k)) == e[k], req, $sformatf("direct lane%0d", k), lane(k), e[k]);
  endtask

  // Gather under the butterfly layout: word index from each chip, sorted, then step check.
  task automatic gather(input logic [CW-1:0] col, input logic [P-1:0] pat,
                        input int d1, input int d2, input int d3);
    int w [N];
    int d [3];
    int t;
    cmd(3'd3, col, pat, "R9");
    for (int k = 0; k < N; k++) w[k] = int'(lane(k)) * N + (k ^ (int'(lane(k)) % N));
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (w[j] > w[j+1]) begin t = w[j]; w[j] = w[j+1]; w[j+1] = t; end
    d[0] = d1; d[1] = d2; d[2] = d3;
    for (int i = 0; i < 3; i++)
      chk(w[i+1] - w[i] == d[i], "R9", $sformatf("col %0d pat %0d step%0d", col, pat, i),
          w[i+1] - w[i], d[i]);
  endtask

  initial begin
    for (int k = 0; k < N; k++) mid[k] = k;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready in reset", cmd_ready, 1);
    rst_n = 1'b1;

    // R4 stated examples
    cmd(3'd3, 8'd0, 3'd3, "R4");
    expect_lanes(0, 1, 2, 3, "R4");
    cmd(3'd3, 8'd2, 3'd0, "R4");
    expect_lanes(2, 2, 2, 2, "R4");

    // R1 pass-through for non-column codes
    cmd(3'd1, 8'h5A, 3'd7, "R1");
    expect_lanes('h5A, 'h5A, 'h5A, 'h5A, "R1");
    cmd(3'd2, 8'hC3, 3'd7, "R1");
    cmd(3'd5, 8'h0F, 3'd5, "R1");
    cmd(3'd0, 8'h81, 3'd3, "R1");
    cmd(3'd6, 8'h77, 3'd7, "R1");
    cmd(3'd7, 8'h12, 3'd6, "R1");

    // R2 write translation, upper bits kept
    cmd(3'd4, 8'hF3, 3'd5, "R2");
    expect_lanes('hF3, 'hF6, 'hF3, 'hF6, "R2");
    // R3 default pattern
    cmd(3'd4, 8'hA6, 3'd0, "R3");
    expect_lanes('hA6, 'hA6, 'hA6, 'hA6, "R3");

    // R5 widened identities: pattern 4 flips bit 2 on chips 1 and 3
    cmd(3'd3, 8'd0, 3'd4, "R5");
    expect_lanes(0, 4, 0, 4, "R5");

    // R6 same-edge write uses old identity, later command uses new
    drive(1'b1, 3'd3, 8'd0, 3'd3, 1'b1, 1'b1, 2'd0, 2'd3, "R6");
    chk(lane(0) == 8'd0, "R6", "same-edge old id", lane(0), 0);
    cmd(3'd3, 8'd0, 3'd3, "R6");
    chk(lane(0) == 8'd3, "R6", "new id", lane(0), 3);
    drive(1'b0, 3'd0, 8'd0, 3'd0, 1'b1, 1'b1, 2'd0, 2'd0, "R6");

    // R8 back-pressure
    cmd(3'd3, 8'd10, 3'd3, "R8");
    begin
      logic [N*CW-1:0] held;
      held = out_col;
      drive(1'b1, 3'd4, 8'd20, 3'd1, 1'b0, 1'b0, '0, '0, "R8");
      drive(1'b1, 3'd4, 8'd20, 3'd1, 1'b0, 1'b0, '0, '0, "R8");
      chk(out_col == held, "R8", "held out_col", out_col, held);
      drive(1'b1, 3'd4, 8'd20, 3'd1, 1'b1, 1'b0, '0, '0, "R8");
      drive(1'b0, 3'd0, 8'd0, 3'd0, 1'b1, 1'b0, '0, '0, "R7");
    end

    // R9 gathers with the shuffled layout
    for (int c = 0; c < 4; c++) begin
      gather(8'(c), 3'd0, 1, 1, 1);
      gather(8'(c), 3'd1, 2, 2, 2);
      gather(8'(c), 3'd3, 4, 4, 4);
    end
    gather(8'd0, 3'd2, 1, 7, 1);

    // R2 mixed traffic with random back-pressure and identity writes
    for (int i = 0; i < 80; i++) begin
      drive(($urandom % 4) != 0, 3'($urandom % 8), 8'($urandom), 3'($urandom),
            ($urandom % 4) != 0, ($urandom % 8) == 0, 2'($urandom), 2'($urandom), "R2");
    end
    for (int k = 0; k < N; k++) drive(1'b0, 3'd0, 8'd0, 3'd0, 1'b1, 1'b1, 2'(k), 2'(k), "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule